// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

The block watches a UART receiver for silence. It measures time in baud ticks from the most recent completed frame. When the line has been idle for as long as two whole frames would take, it raises a sticky timeout status. The idle limit follows the configured character format: the number of data bits, whether a parity bit is present, and one or two stop bits.

Two modes decide when a timeout may fire. In interrupt mode, a timeout needs at least one unread byte in the receive FIFO. In DMA mode, the FIFO contents do not matter, and the timeout also raises a DMA stop output so that the transfer halts. Any data already in the FIFO stays there.

Software clears the status with a one-cycle pulse. After a clear or a fire, the detector stays quiet until a new frame arrives. A software reset zeroes all state and holds the counter at zero.

Top module: `rx_timeout`

## Requirements
- R1: After `rst_ni` is released, `timeout_o` and `dma_stop_o` are 0.
- R2: The idle limit is L = 2 × (1 + D + P + S) baud ticks. D is 5 + `data_sel_i` (values 0..3 select 5..8 data bits). P is `parity_en_i`. S is 2 when `two_stop_i` is set and 1 otherwise. `timeout_o` stays 0 after L−1 ticks following a frame. If the mode qualifies, `timeout_o` rises on the first clock edge after the edge that registers the L-th tick.
- R3: In interrupt mode (`dma_mode_i`=0), `timeout_o` does not rise while `fifo_nempty_i` is 0, however long the idle time.
- R4: In interrupt mode, once the limit has elapsed, `fifo_nempty_i` going to 1 sets `timeout_o` on the next clock edge.
- R5: In DMA mode, the timeout fires after L ticks whatever the value of `fifo_nempty_i`, and `dma_stop_o` rises together with `timeout_o`.
- R6: A timeout that fires in interrupt mode leaves `dma_stop_o` at 0.
- R7: `timeout_o` and `dma_stop_o` hold until `clr_i` is pulsed. After the clear, neither rises again, whatever the number of ticks, until a new frame is received.
- R8: A `frame_done_i` pulse restarts the idle count from zero.
- R9: While `sw_rst_i` is 1, the counter stays at zero and both outputs are 0. After release, nothing fires until a frame is received.
- R10: Baud ticks that arrive before any frame has been received never produce a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Software reset, level, active high |
| baud_tick_i | input | 1 | One pulse per bit time |
| frame_done_i | input | 1 | Pulse when a frame has been received |
| fifo_nempty_i | input | 1 | Receive FIFO holds at least one byte |
| dma_mode_i | input | 1 | 1 = DMA mode, 0 = interrupt mode |
| clr_i | input | 1 | Clears the timeout status |
| data_sel_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | A parity bit is present |
| two_stop_i | input | 1 | Two stop bits |
| timeout_o | output | 1 | Sticky timeout status |
| dma_stop_o | output | 1 | Halts the DMA transfer after a timeout in DMA mode |

## Verification
The bench covers all 16 frame formats in both modes, each with the FIFO empty and with it occupied. For each case it checks one tick short of the limit and then exactly at the limit. A limit that is off by one, or that ignores parity or stop bits, misses one of these two checks. With the mode qualifier inverted, the bench sees a timeout on an empty FIFO in interrupt mode. Without re-arming after a frame, the bench sees a second timeout after the clear. Other directed cases show a fire delayed until data arrives, a count restarted by a mid-count frame, and ticks ignored during software reset and before the first frame. Each of these targets a counter that keeps running when it should be held.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int unsigned DATA_BASE  = 5;
  localparam int unsigned DSEL_W     = 2;
  localparam int unsigned MAX_FRAME  = 1 + DATA_BASE + (1 << DSEL_W) - 1 + 1 + 2;
  localparam int unsigned LIMIT_MAX  = 2 * MAX_FRAME;
  localparam int unsigned CNT_W      = $clog2(LIMIT_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic [DSEL_W-1:0] data_sel;
    logic              parity_en;
    logic              two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/rxto_limit.sv
module rxto_limit
  import rxto_pkg::*;
(
  input  frame_cfg_t cfg_i,
  output cnt_t       limit_o
);
  cnt_t frame_bits;

  always_comb begin
    frame_bits = cnt_t'(DATA_BASE + 2)
               + cnt_t'(cfg_i.data_sel)
               + cnt_t'(cfg_i.parity_en)
               + cnt_t'(cfg_i.two_stop);
    limit_o = cnt_t'(frame_bits << 1);
  end
endmodule

// File: rtl/rxto_idle_cnt.sv
module rxto_idle_cnt
  import rxto_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic tick_i,
  input  logic frame_i,
  input  logic fire_i,
  input  cnt_t limit_i,
  output logic elapsed_o
);
  cnt_t cnt_q;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (sw_rst_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (frame_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (fire_i) armed_q <= 1'b0;
      if (armed_q && tick_i && (cnt_q < limit_i)) cnt_q <= cnt_q + cnt_t'(1);
    end
  end

  assign elapsed_o = armed_q && (cnt_q >= limit_i);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sw_rst_i)
    armed_q |-> cnt_q <= limit_i);
  // R9
  sw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (cnt_q == '0) && !armed_q);
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !sw_rst_i) |=> (cnt_q == '0) && armed_q);
endmodule

// File: rtl/rxto_status.sv
module rxto_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic fire_i,
  input  logic dma_mode_i,
  input  logic clr_i,
  output logic timeout_o,
  output logic dma_stop_o
);
  logic to_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (sw_rst_i) begin
      to_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (fire_i) begin
      to_q   <= 1'b1;
      stop_q <= stop_q | dma_mode_i;
    end else if (clr_i) begin
      to_q   <= 1'b0;
      stop_q <= 1'b0;
    end
  end

  assign timeout_o  = to_q;
  assign dma_stop_o = stop_q;

  // R5
  stop_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> to_q);
  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && !clr_i && !sw_rst_i) |=> to_q);
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout
  import rxto_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic              baud_tick_i,
  input  logic              frame_done_i,
  input  logic              fifo_nempty_i,
  input  logic              dma_mode_i,
  input  logic              clr_i,
  input  logic [DSEL_W-1:0] data_sel_i,
  input  logic              parity_en_i,
  input  logic              two_stop_i,
  output logic              timeout_o,
  output logic              dma_stop_o
);
  frame_cfg_t cfg;
  cnt_t       limit;
  logic       elapsed, fire;

  assign cfg = '{data_sel: data_sel_i, parity_en: parity_en_i, two_stop: two_stop_i};

  rxto_limit u_limit (.cfg_i(cfg), .limit_o(limit));

  // interrupt mode needs unread data; DMA mode fires on idle alone
  assign fire = elapsed && !sw_rst_i && !frame_done_i && (dma_mode_i || fifo_nempty_i);

  rxto_idle_cnt u_cnt (
    .clk_i, .rst_ni, .sw_rst_i,
    .tick_i(baud_tick_i), .frame_i(frame_done_i), .fire_i(fire),
    .limit_i(limit), .elapsed_o(elapsed)
  );

  rxto_status u_stat (
    .clk_i, .rst_ni, .sw_rst_i,
    .fire_i(fire), .dma_mode_i, .clr_i,
    .timeout_o, .dma_stop_o
  );

  // R3
  qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(dma_mode_i || fifo_nempty_i));
  // R6
  stop_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_stop_o) |-> $past(dma_mode_i));
endmodule

// File: tb/rx_timeout_test.sv
`timescale 1ns/1ps
module rx_timeout_test;
  logic clk = 0, rst_n = 0;
  logic sw_rst = 0, tick = 0, frame = 0, nempty = 0, dma = 0, clr = 0;
  logic [1:0] dsel = 0;
  logic par = 0, stop2 = 0;
  logic to, dstop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_timeout uut (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .baud_tick_i(tick),
    .frame_done_i(frame), .fifo_nempty_i(nempty), .dma_mode_i(dma), .clr_i(clr),
    .data_sel_i(dsel), .parity_en_i(par), .two_stop_i(stop2),
    .timeout_o(to), .dma_stop_o(dstop)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame = 1;
    @(negedge clk) frame = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic soft_reset(input int cfg);
    @(negedge clk) sw_rst = 1;
    @(negedge clk) {dsel, par, stop2} = cfg[3:0];
    @(negedge clk) sw_rst = 0;
  endtask

  function automatic int lim(input int cfg);
    return 2 * (1 + 5 + cfg[3:2] + cfg[1] + (cfg[0] ? 2 : 1));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(to, 0, "R1 timeout");
    chk(dstop, 0, "R1 dma_stop");

    // R10: ticks with no frame since reset
    nempty = 1;
    ticks(40);
    @(negedge clk);
    chk(to, 0, "R10");
    nempty = 0;

    // R2/R3/R4/R5/R6/R7 sweep
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        int l;
        logic q;
        l = lim(c);
        soft_reset(c);
        dma = m[1]; nempty = m[0];
        q = m[1] | m[0];
        pulse_frame();
        ticks(l - 1);
        @(negedge clk);
        chk(to, 0, "R2 early");
        ticks(1);
        @(negedge clk);
        chk(to, q, m[1] ? "R5 fire" : (m[0] ? "R2 fire" : "R3 empty"));
        chk(dstop, m[1], m[1] ? "R5 stop" : "R6 stop");
        if (!q) begin
          ticks(5);
          nempty = 1;
          @(negedge clk);
          chk(to, 1, "R4 late data");
          chk(dstop, 0, "R6 late");
        end
        ticks(3);
        chk(to, 1, "R7 sticky");
        pulse_clr();
        chk(to, 0, "R7 clear");
        chk(dstop, 0, "R7 clear stop");
        ticks(l + 3);
        @(negedge clk);
        chk(to, 0, "R7 no refire");
      end
    end

    // R8 restart mid-count
    soft_reset(4'b1111);
    dma = 0; nempty = 1;
    pulse_frame();
    ticks(lim(15) - 1);
    pulse_frame();
    ticks(lim(15) - 1);
    @(negedge clk);
    chk(to, 0, "R8 restarted");
    ticks(1);
    @(negedge clk);
    chk(to, 1, "R8 fire");

    // R9 software reset holds counter
    soft_reset(0);
    dma = 1;
    pulse_frame();
    ticks(4);
    @(negedge clk) sw_rst = 1;
    ticks(40);
    chk(to, 0, "R9 during");
    chk(dstop, 0, "R9 during stop");
    @(negedge clk) sw_rst = 0;
    ticks(40);
    @(negedge clk);
    chk(to, 0, "R9 after");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule